// File: doc/BRIEF.md
# Memory Self-Test Pattern Sequencer

This block is a built-in self-test engine for an external synchronous memory. Software programs an address window, a rank, a data pattern and a halt policy through a small word-addressed register bus, then sets a start bit. The engine fills every word of the window with one 4-bit value repeated across the data word, in ascending address order. It then reads the window back in the same order and compares each returned word against that value.

Any mismatch raises a sticky fail flag, increments a saturating error counter and, on the first occurrence, captures the failing address. Software can ask the engine to stop on the first error. In that case the one read already issued is still completed and checked. A running test can be cancelled with an abort bit. The engine flags an abort that comes too soon after the start, measured against a programmable cycle count. Start requests with an illegal rank code or an inverted window are refused and leave the memory port idle.

Top module: `mbist_ctrl`

## Requirements
- R1: After reset every register reads as zero, and the memory port issues neither writes nor reads.
- R2: Control bits 18:16 select the nibble that is repeated across the whole data word: 000→0, 001→F, 010→A, 011→5, 100→C, 101→3, 110→9, 111→6.
- R3: Control bit 30 is the fail flag. A control write loads it, and a read-compare mismatch sets it. It then holds until software writes it again.
- R4: An accepted start first issues one write per cycle for every address from the low bound (register 1) up to the high bound (register 2). It then issues one read per cycle over the same range. A cycle never carries both a write and a read, and control bit 31 reads 1 while the test runs.
- R5: With control bit 29 clear, mismatches do not stop the test. Every address in the window is read, and control bit 26 (done) is set at the end.
- R6: Control bits 21:20 select the rank and drive mem_rank during every access: 01 selects rank 0 and 10 selects rank 1.
- R7: Register 4 holds the address of the first mismatch of the current test. Register 5 counts mismatches. A new test clears both.
- R8: With control bit 29 set, no new read is issued after a mismatch is detected. The read that was issued in that same cycle is still compared and counted, and the test then ends with done set.
- R9: A start request with rank code 00 or 11, or with a low bound above the high bound, is refused. Control bit 24 is set, no memory access follows, and the next accepted start clears bit 24.
- R10: A control write with bit 28 set while a test runs stops all memory accesses from the next cycle. Done is not set.
- R11: While the stored abort bit is 1, a start request is refused. Once software clears the abort bit, a start is accepted again.
- R12: If the abort arrives fewer cycles after the start than the value in register 3, sticky control bit 25 is set. It stays set across other control writes, and only a control write with bit 25 set to 1 clears it.
- R13: The error count in register 5 saturates at 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| mem_addr | output | AW (8) | Memory word address |
| mem_wdata | output | DW (32) | Memory write data (pattern word) |
| mem_rdata | input | DW (32) | Memory read data, valid one cycle after mem_re |
| mem_we | output | 1 | Memory write enable |
| mem_re | output | 1 | Memory read enable |
| mem_rank | output | 2 | Rank select code |

## Verification
The bench targets the halt-on-error case with two adjacent faulty words. A design that stopped at once would report one error and three reads instead of two errors and four. A design that ignored the halt bit would issue all eight reads. Refused starts with a reserved rank, an inverted window or a still-set abort bit are each checked by watching for write traffic. A design that started anyway would produce writes the scoreboard does not expect. An early abort and a late abort are both applied, so a violation flag with a reversed comparison, or one that is not sticky, would read wrongly. A full-range run in which every word fails exposes a counter that wraps to zero instead of holding at 255.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_WR    = 2'd1,
      ST_RD    = 2'd2,
      ST_DRAIN = 2'd3
   } seq_state_t;

   localparam logic [2:0] RA_CTRL  = 3'd0;
   localparam logic [2:0] RA_LO    = 3'd1;
   localparam logic [2:0] RA_HI    = 3'd2;
   localparam logic [2:0] RA_GAP   = 3'd3;
   localparam logic [2:0] RA_FADDR = 3'd4;
   localparam logic [2:0] RA_ECNT  = 3'd5;

   localparam int B_START = 31;
   localparam int B_FAIL  = 30;
   localparam int B_HALT  = 29;
   localparam int B_ABORT = 28;
   localparam int B_DONE  = 26;
   localparam int B_VIOL  = 25;
   localparam int B_REFUS = 24;
   localparam int B_RANK  = 20;
   localparam int B_PAT   = 16;

   function automatic logic [3:0] pat_nibble(input logic [2:0] sel);
      logic [3:0] n;
      case (sel)
         3'd0:    n = 4'h0;
         3'd1:    n = 4'hF;
         3'd2:    n = 4'hA;
         3'd3:    n = 4'h5;
         3'd4:    n = 4'hC;
         3'd5:    n = 4'h3;
         3'd6:    n = 4'h9;
         default: n = 4'h6;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/mbist_regs.sv
module mbist_regs
   import mbist_pkg::*;
#(
   parameter int AW    = 8,
   parameter int CNT_W = 8,
   parameter int GAP_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_we,
   input  logic [2:0]       reg_addr,
   input  logic [31:0]      reg_wdata,
   output logic [31:0]      reg_rdata,
   input  logic             busy,
   input  logic             test_end,
   input  logic             mismatch,
   input  logic [AW-1:0]    fail_addr,
   input  logic [CNT_W-1:0] err_cnt,
   output logic             start_acc,
   output logic             abort_req,
   output logic             halt_en,
   output logic             fail_o,
   output logic [1:0]       rank,
   output logic [2:0]       pat_sel,
   output logic [AW-1:0]    lo_addr,
   output logic [AW-1:0]    hi_addr
);

   localparam logic [GAP_W-1:0] GAP_MAX = '1;

   logic             fail_q, halt_q, abort_q, done_q, viol_q, refused_q;
   logic [1:0]       rank_q;
   logic [2:0]       pat_q;
   logic [AW-1:0]    lo_q, hi_q;
   logic [GAP_W-1:0] gap_q, min_gap_q;

   logic       wr_ctrl, rank_ok, range_ok, refuse;
   logic [1:0] new_rank;
   logic       unused_wdata;

   assign unused_wdata = ^reg_wdata;

   assign wr_ctrl  = reg_we && (reg_addr == RA_CTRL);
   assign new_rank = reg_wdata[B_RANK +: 2];
   assign rank_ok  = (new_rank == 2'b01) || (new_rank == 2'b10);
   assign range_ok = (lo_q <= hi_q);

   assign start_acc = wr_ctrl && reg_wdata[B_START] && !reg_wdata[B_ABORT]
                      && !abort_q && !busy && rank_ok && range_ok;
   assign refuse    = wr_ctrl && reg_wdata[B_START] && !busy && !start_acc;
   assign abort_req = wr_ctrl && reg_wdata[B_ABORT] && busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fail_q    <= 1'b0;
         halt_q    <= 1'b0;
         abort_q   <= 1'b0;
         done_q    <= 1'b0;
         viol_q    <= 1'b0;
         refused_q <= 1'b0;
         rank_q    <= 2'b00;
         pat_q     <= 3'b000;
      end else begin
         if (mismatch)
            fail_q <= 1'b1;
         else if (wr_ctrl)
            fail_q <= reg_wdata[B_FAIL];

         if (wr_ctrl) abort_q <= reg_wdata[B_ABORT];

         if (wr_ctrl && !busy) begin
            halt_q <= reg_wdata[B_HALT];
            rank_q <= new_rank;
            pat_q  <= reg_wdata[B_PAT +: 3];
         end

         if (start_acc)     done_q <= 1'b0;
         else if (test_end) done_q <= 1'b1;

         if (start_acc)   refused_q <= 1'b0;
         else if (refuse) refused_q <= 1'b1;

         if (abort_req && (gap_q < min_gap_q))
            viol_q <= 1'b1;
         else if (wr_ctrl && reg_wdata[B_VIOL])
            viol_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q      <= '0;
         hi_q      <= '0;
         min_gap_q <= '0;
         gap_q     <= '0;
      end else begin
         if (reg_we && !busy && reg_addr == RA_LO) lo_q <= reg_wdata[AW-1:0];
         if (reg_we && !busy && reg_addr == RA_HI) hi_q <= reg_wdata[AW-1:0];
         if (reg_we && reg_addr == RA_GAP) min_gap_q <= reg_wdata[GAP_W-1:0];
         if (start_acc)
            gap_q <= '0;
         else if (busy && gap_q != GAP_MAX)
            gap_q <= gap_q + 1'b1;
      end
   end

   always_comb begin
      case (reg_addr)
         RA_CTRL:  reg_rdata = {busy, fail_q, halt_q, abort_q, 1'b0, done_q, viol_q,
                                refused_q, 2'b00, rank_q, 1'b0, pat_q, 16'h0000};
         RA_LO:    reg_rdata = 32'(lo_q);
         RA_HI:    reg_rdata = 32'(hi_q);
         RA_GAP:   reg_rdata = 32'(min_gap_q);
         RA_FADDR: reg_rdata = 32'(fail_addr);
         RA_ECNT:  reg_rdata = 32'(err_cnt);
         default:  reg_rdata = 32'h0;
      endcase
   end

   assign halt_en = halt_q;
   assign fail_o  = fail_q;
   assign rank    = rank_q;
   assign pat_sel = pat_q;
   assign lo_addr = lo_q;
   assign hi_addr = hi_q;

endmodule

// File: rtl/mbist_seq.sv
module mbist_seq
   import mbist_pkg::*;
#(
   parameter int AW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          abort,
   input  logic          halt,
   input  logic [AW-1:0] lo_addr,
   input  logic [AW-1:0] hi_addr,
   output logic [AW-1:0] mem_addr,
   output logic          mem_we,
   output logic          mem_re,
   output logic          busy,
   output logic          test_end
);

   seq_state_t    st;
   logic [AW-1:0] addr_q;
   logic          at_last;

   assign at_last = (addr_q == hi_addr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         addr_q <= '0;
      end else if (abort) begin
         st <= ST_IDLE;
      end else begin
         case (st)
            ST_IDLE: if (start) begin
               st     <= ST_WR;
               addr_q <= lo_addr;
            end
            ST_WR: if (at_last) begin
               st     <= ST_RD;
               addr_q <= lo_addr;
            end else begin
               addr_q <= addr_q + 1'b1;
            end
            ST_RD: if (halt || at_last)
               st <= ST_DRAIN;
            else
               addr_q <= addr_q + 1'b1;
            ST_DRAIN: st <= ST_IDLE;
            default:  st <= ST_IDLE;
         endcase
      end
   end

   assign mem_addr = addr_q;
   assign mem_we   = (st == ST_WR);
   assign mem_re   = (st == ST_RD);
   assign busy     = (st != ST_IDLE);
   assign test_end = (st == ST_DRAIN);

endmodule

// File: rtl/mbist_cmp.sv
module mbist_cmp #(
   parameter int AW    = 8,
   parameter int DW    = 32,
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             kill,
   input  logic             rd_issue,
   input  logic [AW-1:0]    issue_addr,
   input  logic [DW-1:0]    rdata,
   input  logic [DW-1:0]    expect_word,
   output logic             mismatch,
   output logic [CNT_W-1:0] err_cnt,
   output logic [AW-1:0]    first_addr
);

   localparam int LANES = DW / 4;
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic             vld_q;
   logic [AW-1:0]    addr_q;
   logic [LANES-1:0] lane_bad;
   logic [CNT_W-1:0] cnt_q;
   logic [AW-1:0]    first_q;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane_bad[g] = (rdata[g*4 +: 4] != expect_word[g*4 +: 4]);
   end

   assign mismatch = vld_q && (|lane_bad);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q   <= 1'b0;
         addr_q  <= '0;
         cnt_q   <= '0;
         first_q <= '0;
      end else begin
         vld_q  <= rd_issue && !kill;
         addr_q <= issue_addr;
         if (clear) begin
            cnt_q   <= '0;
            first_q <= '0;
         end else if (mismatch) begin
            if (cnt_q == '0) first_q <= addr_q;
            if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign err_cnt    = cnt_q;
   assign first_addr = first_q;

endmodule

// File: rtl/mbist_ctrl.sv
module mbist_ctrl
   import mbist_pkg::*;
#(
   parameter int AW    = 8,
   parameter int DW    = 32,
   parameter int CNT_W = 8,
   parameter int GAP_W = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_we,
   input  logic [2:0]    reg_addr,
   input  logic [31:0]   reg_wdata,
   output logic [31:0]   reg_rdata,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata,
   output logic          mem_we,
   output logic          mem_re,
   output logic [1:0]    mem_rank
);

   localparam int LANES = DW / 4;

   initial begin
      assert (DW >= 4 && (DW % 4) == 0) else $error("DW must be a multiple of 4");
      assert (AW >= 1 && AW <= 32)      else $error("AW out of range");
      assert (CNT_W >= 1 && CNT_W <= 32) else $error("CNT_W out of range");
      assert (GAP_W >= 1 && GAP_W <= 32) else $error("GAP_W out of range");
   end

   logic             start_acc, abort_req, halt_en, fail_flag;
   logic             busy, test_end, mismatch;
   logic [1:0]       rank;
   logic [2:0]       pat_sel;
   logic [AW-1:0]    lo_addr, hi_addr, first_addr;
   logic [CNT_W-1:0] err_cnt;
   logic [3:0]       nib;
   logic [DW-1:0]    pat_word;

   assign nib = pat_nibble(pat_sel);

   for (genvar g = 0; g < LANES; g++) begin : g_pat
      assign pat_word[g*4 +: 4] = nib;
   end

   mbist_regs #(.AW(AW), .CNT_W(CNT_W), .GAP_W(GAP_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (reg_we),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .busy      (busy),
      .test_end  (test_end),
      .mismatch  (mismatch),
      .fail_addr (first_addr),
      .err_cnt   (err_cnt),
      .start_acc (start_acc),
      .abort_req (abort_req),
      .halt_en   (halt_en),
      .fail_o    (fail_flag),
      .rank      (rank),
      .pat_sel   (pat_sel),
      .lo_addr   (lo_addr),
      .hi_addr   (hi_addr)
   );

   mbist_seq #(.AW(AW)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start_acc),
      .abort    (abort_req),
      .halt     (mismatch && halt_en),
      .lo_addr  (lo_addr),
      .hi_addr  (hi_addr),
      .mem_addr (mem_addr),
      .mem_we   (mem_we),
      .mem_re   (mem_re),
      .busy     (busy),
      .test_end (test_end)
   );

   mbist_cmp #(.AW(AW), .DW(DW), .CNT_W(CNT_W)) u_cmp (
      .clk         (clk),
      .rst_n       (rst_n),
      .clear       (start_acc),
      .kill        (abort_req),
      .rd_issue    (mem_re),
      .issue_addr  (mem_addr),
      .rdata       (mem_rdata),
      .expect_word (pat_word),
      .mismatch    (mismatch),
      .err_cnt     (err_cnt),
      .first_addr  (first_addr)
   );

   assign mem_wdata = pat_word;
   assign mem_rank  = rank;

endmodule

// File: rtl/mbist_ctrl_chk.sv
module mbist_ctrl_chk #(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             reg_we,
   input logic [2:0]       reg_addr,
   input logic             mem_we,
   input logic             mem_re,
   input logic [1:0]       mem_rank,
   input logic             busy,
   input logic             start_acc,
   input logic             abort_req,
   input logic             fail_flag,
   input logic [CNT_W-1:0] err_cnt
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   p_one_op_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we && mem_re));

   p_rank_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we || mem_re) |-> (mem_rank == 2'b01 || mem_rank == 2'b10));

   p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !(mem_we || mem_re));

   p_abort_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
      abort_req |=> !busy);

   p_fail_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (fail_flag && !(reg_we && reg_addr == 3'd0)) |=> fail_flag);

   p_cnt_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (err_cnt == CNT_MAX && !start_acc) |=> (err_cnt == CNT_MAX));

endmodule

bind mbist_ctrl mbist_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_we    (reg_we),
   .reg_addr  (reg_addr),
   .mem_we    (mem_we),
   .mem_re    (mem_re),
   .mem_rank  (mem_rank),
   .busy      (busy),
   .start_acc (start_acc),
   .abort_req (abort_req),
   .fail_flag (fail_flag),
   .err_cnt   (err_cnt)
);

// File: tb/mbist_ctrl_tb_top.sv
module mbist_ctrl_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_addr = 3'd0;
   logic [31:0] reg_wdata = 32'h0;
   logic [31:0] reg_rdata;
   logic [7:0]  mem_addr;
   logic [31:0] mem_wdata;
   logic [31:0] mem_rdata = 32'h0;
   logic        mem_we, mem_re;
   logic [1:0]  mem_rank;

   int total = 0;
   int bad = 0;
   int rd_seen = 0;
   int wr_seen = 0;

   logic       fault_en = 1'b0;
   logic       fault_all = 1'b0;
   logic [7:0] fa1 = 8'h00, fa2 = 8'h00;
   logic [31:0] mem_arr [256];

   typedef struct packed {
      logic [7:0]  a;
      logic [31:0] d;
      logic [1:0]  r;
   } wr_item_t;
   wr_item_t exp_q[$];

   always #10 clk = ~clk;

   mbist_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_we(mem_we),
      .mem_re(mem_re), .mem_rank(mem_rank)
   );

   function automatic logic [31:0] flt(input logic [7:0] a);
      if (fault_all) return 32'h0000_0001;
      if (fault_en && (a == fa1 || a == fa2)) return 32'h0000_0100;
      return 32'h0;
   endfunction

   always @(posedge clk) begin
      if (mem_we) mem_arr[mem_addr] <= mem_wdata;
      if (mem_re) mem_rdata <= mem_arr[mem_addr] ^ flt(mem_addr);
   end

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // monitor: pops expected writes and compares
   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_re) rd_seen++;
         if (mem_we) begin
            wr_seen++;
            if (exp_q.size() == 0) begin
               check(1'b0, "R4", "unexpected write addr", {24'h0, mem_addr}, 32'h0);
            end else begin
               wr_item_t it;
               it = exp_q.pop_front();
               check(mem_addr == it.a, "R4", "write address order", {24'h0, mem_addr}, {24'h0, it.a});
               check(mem_wdata == it.d, "R2", "pattern word", mem_wdata, it.d);
               check(mem_rank == it.r, "R6", "rank code", {30'h0, mem_rank}, {30'h0, it.r});
            end
         end
      end
   end

   function automatic logic [3:0] exp_nib(input logic [2:0] s);
      case (s)
         3'd0: return 4'h0;  3'd1: return 4'hF;
         3'd2: return 4'hA;  3'd3: return 4'h5;
         3'd4: return 4'hC;  3'd5: return 4'h3;
         3'd6: return 4'h9;  default: return 4'h6;
      endcase
   endfunction

   task automatic push_writes(input int lo, input int hi, input logic [2:0] pat,
                              input logic [1:0] rk);
      for (int a = lo; a <= hi; a++) begin
         wr_item_t it;
         it.a = 8'(a);
         it.d = {8{exp_nib(pat)}};
         it.r = rk;
         exp_q.push_back(it);
      end
   endtask

   function automatic logic [31:0] mk_ctrl(input bit st, input bit fl, input bit hl,
                                           input bit ab, input logic [1:0] rk,
                                           input logic [2:0] pat);
      logic [31:0] w;
      w = 32'h0;
      w[31] = st; w[30] = fl; w[29] = hl; w[28] = ab;
      w[21:20] = rk; w[18:16] = pat;
      return w;
   endfunction

   task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic wait_done(input string req);
      logic [31:0] v;
      int n;
      n = 0;
      do begin
         reg_rd(3'd0, v);
         n++;
      end while (!v[26] && n < 2000);
      check(v[26] == 1'b1, req, "done bit", {31'h0, v[26]}, 32'h1);
   endtask

   task automatic run_window(input int lo, input int hi);
      reg_wr(3'd1, 32'(lo));
      reg_wr(3'd2, 32'(hi));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] v;
      int r0, w0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      reg_rd(3'd0, v); check(v == 32'h0, "R1", "ctrl after reset", v, 32'h0);
      reg_rd(3'd4, v); check(v == 32'h0, "R1", "first-fail after reset", v, 32'h0);
      reg_rd(3'd5, v); check(v == 32'h0, "R1", "error count after reset", v, 32'h0);
      check(!mem_we && !mem_re, "R1", "port idle after reset", {30'h0, mem_we, mem_re}, 32'h0);

      // R9: reserved rank 00 refused
      run_window(16, 23);
      w0 = wr_seen;
      reg_wr(3'd0, mk_ctrl(1, 0, 0, 0, 2'b00, 3'd2));
      repeat (5) @(negedge clk);
      reg_rd(3'd0, v);
      check(v[31] == 1'b0, "R9", "rank 00 not running", {31'h0, v[31]}, 32'h0);
      check(v[24] == 1'b1, "R9", "refused flag set", {31'h0, v[24]}, 32'h1);
      check(wr_seen == w0, "R9", "no writes after refusal", 32'(wr_seen - w0), 32'h0);

      // R2/R4/R5/R6: clean pass, pattern A on rank 0
      push_writes(16, 23, 3'd2, 2'b01);
      r0 = rd_seen;
      reg_wr(3'd0, mk_ctrl(1, 0, 0, 0, 2'b01, 3'd2));
      reg_rd(3'd0, v);
      check(v[31] == 1'b1, "R4", "start bit reads 1 while running", {31'h0, v[31]}, 32'h1);
      check(v[24] == 1'b0, "R9", "refused flag cleared by good start", {31'h0, v[24]}, 32'h0);
      wait_done("R5");
      reg_rd(3'd0, v);
      check(v[30] == 1'b0, "R3", "fail flag on clean run", {31'h0, v[30]}, 32'h0);
      check(rd_seen - r0 == 8, "R4", "read count clean run", 32'(rd_seen - r0), 32'd8);
      check(exp_q.size() == 0, "R4", "all writes seen", 32'(exp_q.size()), 32'h0);

      // R9: inverted window refused
      run_window(5, 2);
      w0 = wr_seen;
      reg_wr(3'd0, mk_ctrl(1, 0, 0, 0, 2'b10, 3'd1));
      repeat (5) @(negedge clk);
      reg_rd(3'd0, v);
      check(v[24] == 1'b1 && v[31] == 1'b0, "R9", "low above high refused", v, 32'h0100_0000);
      check(wr_seen == w0, "R9", "no writes on inverted window", 32'(wr_seen - w0), 32'h0);

      // R8: halt on error with two adjacent faults, rank 1, pattern 6
      fault_en = 1'b1; fa1 = 8'h22; fa2 = 8'h23;
      run_window(32'h20, 32'h27);
      push_writes(32'h20, 32'h27, 3'd7, 2'b10);
      r0 = rd_seen;
      reg_wr(3'd0, mk_ctrl(1, 0, 1, 0, 2'b10, 3'd7));
      wait_done("R8");
      check(rd_seen - r0 == 4, "R8", "reads issued with halt", 32'(rd_seen - r0), 32'd4);
      reg_rd(3'd5, v); check(v == 32'd2, "R8", "errors incl. in-flight read", v, 32'd2);
      reg_rd(3'd4, v); check(v == 32'h22, "R7", "first failing address", v, 32'h22);
      reg_rd(3'd0, v); check(v[30] == 1'b1, "R3", "fail flag set", {31'h0, v[30]}, 32'h1);

      // R5/R7: same faults, no halt
      push_writes(32'h20, 32'h27, 3'd7, 2'b10);
      r0 = rd_seen;
      reg_wr(3'd0, mk_ctrl(1, 0, 0, 0, 2'b10, 3'd7));
      wait_done("R5");
      check(rd_seen - r0 == 8, "R5", "all reads without halt", 32'(rd_seen - r0), 32'd8);
      reg_rd(3'd5, v); check(v == 32'd2, "R7", "error count", v, 32'd2);
      reg_rd(3'd4, v); check(v == 32'h22, "R7", "first failing address", v, 32'h22);
      fault_en = 1'b0;

      // R10/R11: late abort then blocked restart
      reg_wr(3'd3, 32'd4);
      run_window(0, 255);
      push_writes(0, 255, 3'd3, 2'b01);
      reg_wr(3'd0, mk_ctrl(1, 0, 0, 0, 2'b01, 3'd3));
      repeat (20) @(negedge clk);
      reg_wr(3'd0, mk_ctrl(0, 0, 0, 1, 2'b01, 3'd3));
      check(!mem_we && !mem_re, "R10", "port idle after abort", {30'h0, mem_we, mem_re}, 32'h0);
      reg_rd(3'd0, v);
      check(v[31] == 1'b0 && v[26] == 1'b0, "R10", "stopped, no done", v & 32'h8400_0000, 32'h0);
      check(v[25] == 1'b0, "R12", "no violation on late abort", {31'h0, v[25]}, 32'h0);
      exp_q.delete();
      w0 = wr_seen;
      reg_wr(3'd0, mk_ctrl(1, 0, 0, 0, 2'b01, 3'd3));
      repeat (4) @(negedge clk);
      reg_rd(3'd0, v);
      check(v[31] == 1'b0 && v[24] == 1'b1, "R11", "start refused with abort set", v & 32'h8100_0000, 32'h0100_0000);
      check(wr_seen == w0, "R11", "no writes while abort set", 32'(wr_seen - w0), 32'h0);
      reg_wr(3'd0, mk_ctrl(0, 0, 0, 0, 2'b01, 3'd1));
      run_window(32'h30, 32'h31);
      push_writes(32'h30, 32'h31, 3'd1, 2'b01);
      reg_wr(3'd0, mk_ctrl(1, 0, 0, 0, 2'b01, 3'd1));
      wait_done("R11");
      check(exp_q.size() == 0, "R11", "restart after clearing abort", 32'(exp_q.size()), 32'h0);

      // R12: early abort
      reg_wr(3'd3, 32'd50);
      run_window(0, 255);
      push_writes(0, 255, 3'd0, 2'b01);
      reg_wr(3'd0, mk_ctrl(1, 0, 0, 0, 2'b01, 3'd0));
      reg_wr(3'd0, mk_ctrl(0, 0, 0, 1, 2'b01, 3'd0));
      exp_q.delete();
      reg_rd(3'd0, v);
      check(v[25] == 1'b1, "R12", "violation on early abort", {31'h0, v[25]}, 32'h1);
      reg_wr(3'd0, mk_ctrl(0, 0, 0, 0, 2'b01, 3'd0));
      reg_rd(3'd0, v);
      check(v[25] == 1'b1, "R12", "violation sticky", {31'h0, v[25]}, 32'h1);
      reg_wr(3'd0, mk_ctrl(0, 0, 0, 0, 2'b01, 3'd0) | 32'h0200_0000);
      reg_rd(3'd0, v);
      check(v[25] == 1'b0, "R12", "violation cleared by write-one", {31'h0, v[25]}, 32'h0);

      // R13: every word fails over full range
      fault_all = 1'b1;
      push_writes(0, 255, 3'd5, 2'b10);
      reg_wr(3'd0, mk_ctrl(1, 0, 0, 0, 2'b10, 3'd5));
      wait_done("R13");
      reg_rd(3'd5, v); check(v == 32'd255, "R13", "error count saturates", v, 32'd255);
      reg_rd(3'd4, v); check(v == 32'h0, "R7", "first fail at low bound", v, 32'h0);
      fault_all = 1'b0;

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule